// File: doc/BRIEF.md
# Two-Wire Byte Shifter with Output Delay

This block moves one 9-bit frame across the data line of a two-wire serial bus: a byte followed by an acknowledge bit. A separate clock generator supplies one-cycle strobes that mark the rising and falling edges of the transfer clock. The block uses these strobes to present transmit bits and to sample receive bits. Transmit bits change after each falling strobe. The change can be held back by a programmable number of count-source cycles, which gives hold time on the data line. Receive bits are sampled on each rising strobe and collected into a 9-bit receive word.

A load pulse starts a frame. It captures the transmit byte and the acknowledge bit, and it clears the received-bit count. The receive word can be filled in two layouts. In the normal layout the data byte sits in the low eight bits. In the alternate layout the first seven bits are packed low and the eighth bit is placed on top. A clock-phase option converts the alternate layout back to the normal one at the ninth bit. A release input takes the data pin out of drive at any time. The idle output level can be preset only while the serial function is switched off and two-wire mode is selected.

Top module: `twb_shifter`

## Requirements
- R1: On the first nine falling strobes after a load, the data output presents the transmit byte from bit 7 down to bit 0 and then the acknowledge bit. Every later falling strobe presents 1.
- R2: With `dly_sel` = 0, the data output takes its new value at the clock edge that samples the falling strobe. With `dly_sel` = d (1 to 7), the update comes d+1 cycles later than that, so the total delay is 2 to 8 cycles. The output keeps its old value until then.
- R3: While `sda_release` is 1, `sda_en` is 0 whatever the shift state, and the delayed data update still happens on time. When `sda_release` is 0, `sda_en` is 1.
- R4: `init_wr` sets the data output to `init_lvl` on the next edge only when `ser_off` = 1 and `tw_mode` = 1. In any other case `init_wr` leaves the output unchanged.
- R5: In normal mapping (`alt_map` = 0), the ninth rising strobe sets `rx_word` to {ninth bit, bits 1..8}. The first bit received lands in `rx_word[7]`.
- R6: In alternate mapping, the eighth rising strobe sets `rx_word` to {eighth bit, 0, bits 1..7}, with the first bit in `rx_word[6]`. If `ckph` = 0, the ninth rising strobe then writes only `rx_word[7]`, with the ninth bit.
- R7: In alternate mapping with `ckph` = 1, the ninth rising strobe sets `rx_word` to the same value as normal mapping would give.
- R8: Rising strobes after the ninth one of a frame leave `rx_word` unchanged. `rx_word` also holds its value between frames and across a load.
- R9: A load in the middle of a frame restarts both the transmit sequence and the receive bit count.
- R10: After reset, the data output is 1, `sda_en` is 1 and `rx_word` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Count-source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load | input | 1 | Starts a frame: captures `tx_byte` and `tx_ack` |
| tx_byte | input | 8 | Byte to transmit |
| tx_ack | input | 1 | Ninth bit to transmit |
| dly_sel | input | 3 | Output delay select: 0 = none, d = d+1 extra cycles |
| sda_release | input | 1 | Forces the data pin to high impedance |
| ser_off | input | 1 | Serial function disabled |
| tw_mode | input | 1 | Two-wire mode selected |
| init_wr | input | 1 | Preset strobe for the idle output level |
| init_lvl | input | 1 | Preset level |
| alt_map | input | 1 | Selects the alternate receive layout |
| ckph | input | 1 | Clock-phase option |
| scl_rise | input | 1 | Rising transfer-clock strobe |
| scl_fall | input | 1 | Falling transfer-clock strobe |
| sda_in | input | 1 | Sampled data pin |
| sda_out | output | 1 | Data output level |
| sda_en | output | 1 | Data output enable |
| rx_word | output | 9 | Receive word |

## Verification
The release control can change while a delayed transmit update is still counting down. The bench raises `sda_release` right after a falling strobe with the longest delay. It checks that `sda_en` drops at once, that the data level stays unchanged through the eighth cycle, and that it lands on the ninth. The eighth and ninth rising strobes in alternate mapping both rewrite `rx_word`. The bench checks the word after each of these strobes, with the clock-phase option both off and on, for every delay setting.

// File: rtl/twb_shifter.sv
module twb_shifter #(
  parameter int DW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [7:0]    tx_byte,
  input  logic          tx_ack,
  input  logic [DW-1:0] dly_sel,
  input  logic          sda_release,
  input  logic          ser_off,
  input  logic          tw_mode,
  input  logic          init_wr,
  input  logic          init_lvl,
  input  logic          alt_map,
  input  logic          ckph,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          sda_in,
  output logic          sda_out,
  output logic          sda_en,
  output logic [8:0]    rx_word
);
  localparam int CW = DW + 1;

  logic [8:0]  tsh;
  logic        pend;
  logic [CW-1:0] dcnt;
  logic [8:0]  rsh;
  logic [3:0]  rcnt;
  logic [8:0]  rnxt;
  logic [3:0]  rcnt_n;
  logic        init_ok;

  assign init_ok = init_wr && ser_off && tw_mode;
  assign sda_en  = !sda_release;
  assign rnxt    = {rsh[7:0], sda_in};
  assign rcnt_n  = rcnt + 4'd1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tsh     <= '1;
      pend    <= 1'b1;
      dcnt    <= '0;
      sda_out <= 1'b1;
    end else if (load) begin
      tsh  <= {tx_byte, tx_ack};
      dcnt <= '0;
    end else if (scl_fall) begin
      tsh <= {tsh[7:0], 1'b1};
      if (dly_sel == '0) begin
        sda_out <= tsh[8];
        dcnt    <= '0;
      end else begin
        pend <= tsh[8];
        dcnt <= CW'(dly_sel) + CW'(1);
      end
    end else if (dcnt != '0) begin
      dcnt <= dcnt - CW'(1);
      if (dcnt == CW'(1)) sda_out <= pend;
    end else if (init_ok) begin
      sda_out <= init_lvl;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsh     <= '0;
      rcnt    <= '0;
      rx_word <= '0;
    end else if (load) begin
      rcnt <= '0;
    end else if (scl_rise && rcnt < 4'd9) begin
      rsh  <= rnxt;
      rcnt <= rcnt_n;
      if (alt_map && rcnt_n == 4'd8)
        rx_word <= {rnxt[0], 1'b0, rnxt[7:1]};
      else if (rcnt_n == 4'd9) begin
        if (!alt_map || ckph) rx_word <= {rnxt[0], rnxt[8:1]};
        else                  rx_word[7] <= rnxt[0];
      end
    end
  end

  p_wait_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (dcnt > CW'(1) && !load && !scl_fall) |=> $stable(sda_out));

  p_bitcnt_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rcnt <= 4'd9);

  p_rxhold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !scl_rise |=> $stable(rx_word));

  p_initgate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_fall && dcnt == '0 && !(ser_off && tw_mode)) |=> $stable(sda_out));

  p_rcnt_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> rcnt == 4'd0);
endmodule

// File: tb/twb_shifter_test.sv
module twb_shifter_test;
  localparam time PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic load = 0, tx_ack = 0, sda_release = 0, ser_off = 0, tw_mode = 0;
  logic init_wr = 0, init_lvl = 0, alt_map = 0, ckph = 0;
  logic scl_rise = 0, scl_fall = 0, sda_in = 0;
  logic [7:0] tx_byte = 0;
  logic [2:0] dly_sel = 0;
  logic sda_out, sda_en;
  logic [8:0] rx_word;

  int checks = 0, fails = 0;
  logic exp_out = 1'b1;
  logic [8:0] exp_rx = '0;

  always #(PERIOD/2) clk = ~clk;

  twb_shifter uut (.*);

  task automatic chk(string req, logic [8:0] act, logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask

  task automatic do_load(logic [7:0] b, logic a);
    tx_byte = b; tx_ack = a; load = 1; tick(); load = 0; tick();
  endtask

  task automatic do_fall(logic nv, int d, bit rel);
    scl_fall = 1; tick(); scl_fall = 0;
    if (rel) sda_release = 1;
    if (d == 0) chk("R2 nodelay", sda_out, nv);
    else begin
      repeat (d) tick();
      chk("R2 held", sda_out, exp_out);
      if (rel) chk("R3 en", sda_en, 0);
      tick();
      chk("R2 landed", sda_out, nv);
    end
    if (rel) begin sda_release = 0; tick(); chk("R3 en back", sda_en, 1); end
    exp_out = nv;
  endtask

  task automatic do_rise(logic b);
    sda_in = b; scl_rise = 1; tick(); scl_rise = 0; tick();
  endtask

  initial begin
    #(PERIOD*200000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [8:0] tv, rv;
    tick(); tick();
    rst_n = 1; tick();
    chk("R10 out", sda_out, 1);
    chk("R10 en", sda_en, 1);
    chk("R10 rx", rx_word, 0);

    init_lvl = 0; init_wr = 1; ser_off = 0; tw_mode = 1; tick(); init_wr = 0; tick();
    chk("R4 blocked on", sda_out, 1);
    init_wr = 1; ser_off = 1; tw_mode = 0; tick(); init_wr = 0; tick();
    chk("R4 blocked mode", sda_out, 1);
    init_wr = 1; tw_mode = 1; tick(); init_wr = 0; tick();
    chk("R4 loaded", sda_out, 0);
    exp_out = 0;
    init_lvl = 1; init_wr = 1; tick(); init_wr = 0; tick();
    chk("R4 loaded hi", sda_out, 1);
    exp_out = 1; ser_off = 0; tw_mode = 0;

    do_load(8'h5A, 1'b0);
    for (int k = 0; k < 4; k++) begin
      tv = {8'h5A, 1'b0};
      do_fall(tv[8-k], 0, 0);
      do_rise(1'b1);
    end
    chk("R8 rx kept midframe", rx_word, 0);

    for (int d = 0; d < 8; d++) begin
      for (int m = 0; m < 4; m++) begin
        tv = 9'((d * 73 + m * 29 + 17) & 9'h1FF);
        rv = 9'((d * 151 + m * 47 + 99) & 9'h1FF);
        alt_map = m[1]; ckph = m[0]; dly_sel = 3'(d);
        do_load(tv[8:1], tv[0]);
        chk("R8 rx across load", rx_word, exp_rx);
        for (int k = 0; k < 9; k++) begin
          do_fall(tv[8-k], d, (d == 7 && k == 3));
          do_rise(rv[8-k]);
          if (k == 7 && alt_map) begin
            exp_rx = {rv[1], 1'b0, rv[8:2]};
            chk("R6 alt eighth", rx_word, exp_rx);
          end
          if (k == 8) begin
            if (!alt_map) begin
              exp_rx = {rv[0], rv[8:1]};
              chk("R5 normal", rx_word, exp_rx);
            end else if (ckph) begin
              exp_rx = {rv[0], rv[8:1]};
              chk("R7 alt ckph", rx_word, exp_rx);
            end else begin
              exp_rx = {rv[1], rv[0], rv[8:2]};
              chk("R6 alt ninth", rx_word, exp_rx);
            end
          end
        end
        chk("R1 ack bit", sda_out, tv[0]);
        do_fall(1'b1, d, 0);
        chk("R1 idle after ninth", sda_out, 1);
        do_rise(~rv[0]);
        chk("R8 tenth rise", rx_word, exp_rx);
      end
    end

    dly_sel = 0; alt_map = 0; ckph = 0;
    do_load(8'h0F, 1'b1);
    do_fall(1'b0, 0, 0);
    chk("R9 restart first", sda_out, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule